// File: doc/BRIEF.md
# Split interrupt status controller

This block holds the interrupt state of a network controller. Event inputs from the receive and transmit paths may be single-cycle pulses or held levels. Each one sets a sticky status bit, which stays set until software acts on it. A second register holds one enable bit per status bit. The set-and-enabled bits are folded into two registered interrupt lines: one for the receive group and one for the transmit group.

Software uses a small word-addressed register bus with no wait states. The status word is at byte offset 0x0 and the enable word is at byte offset 0x4. Read data is combinational from the addressed register.

A write of 1 to a status bit toggles it. A set bit is acknowledged and cleared. A clear bit is forced set, which lets diagnostic code inject an interrupt. A write of 0 leaves the bit alone. If a source is active in the same cycle as a clearing write, the source wins.

Top module: `net_irq_status_ctrl`

## Requirements
- R1: After reset, the status register and the enable register both read 0x0000_0000, and `irq_rx` and `irq_tx` are low.
- R2: The implemented status and enable bits are bits 25..16 and bits 6, 4, 3, 2, 1 and 0 (mask 0x03FF_005F). All other bits behave as follows: they read 0, writes to them are ignored, events on them are ignored, and they never drive an interrupt.
- R3: An implemented status bit whose `evt_in` bit is 1 at a clock edge reads 1 after that edge. It stays 1, with no further event, until software clears it.
- R4: A write of 1 to a status bit that is 1 clears it after the write edge. A write of 0 leaves the bit unchanged.
- R5: A write of 1 to a status bit that is 0 sets it after the write edge (diagnostic injection).
- R6: If a bit's event input is 1 in the same cycle as a write that would clear it, the bit stays 1.
- R7: `irq_rx` is high exactly one clock after at least one bit in 25..16 is both set and enabled. It is low one clock after no such bit remains.
- R8: `irq_tx` follows the same rule for bits 6..0. It is independent of the receive group.
- R9: The enable register at byte offset 0x4 is plain read/write. It reads back the written value masked to the implemented bits after the write edge.
- R10: A bus address other than 0x0 and 0x4 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_in | input | 32 | Event inputs, bit n feeding status bit n |
| irq_rx | output | 1 | Registered receive-group interrupt |
| irq_tx | output | 1 | Registered transmit-group interrupt |

## Verification
A write or an event sampled at edge k is visible on `bus_rdata` from just after edge k, once the bus addresses the register. The interrupt lines show it from just after edge k+1, because they are registered one stage behind the status and enable bits. The bench drives its inputs two nanoseconds after each rising edge. It compares every output at the falling edge against a behavioural model that advances on the same rising edges. The directed checks therefore read the status in the cycle after a write and the interrupt lines one cycle after that.

// File: rtl/net_irq_pkg.sv
// Package: shared register selectors and mask helper for the split
// interrupt status controller. Assumes byte addressing with 32-bit words.
package net_irq_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_EN   = 2'd2
    } reg_sel_e;

    // Contiguous mask with bits lo..hi set, up to 64 bits wide.
    function automatic logic [63:0] span_mask(input int lo, input int hi);
        logic [63:0] m;
        m = '0;
        for (int b = 0; b < 64; b++) begin
            if (b >= lo && b <= hi) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
// Address decoder: maps a byte address onto the status or enable register.
// Assumes the two registers sit at parameterised byte offsets; any other
// address selects nothing.
module irq_addr_decode #(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] OFF_STAT = '0,
    parameter logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(4)
) (
    input  logic [ADDR_W-1:0]   addr,
    output net_irq_pkg::reg_sel_e sel
);
    // Pure compare of the full address against both offsets.
    always_comb begin
        if (addr == OFF_STAT)    sel = net_irq_pkg::SEL_STAT;
        else if (addr == OFF_EN) sel = net_irq_pkg::SEL_EN;
        else                     sel = net_irq_pkg::SEL_NONE;
    end
endmodule

// File: rtl/irq_status_bits.sv
// Sticky status bits. An event sets a bit. A write of 1 toggles it, which
// clears a set bit and sets a clear bit. An event overrides a clear in the
// same cycle. Bits outside IMPL_MASK are tied to zero and have no flop.
module irq_status_bits #(
    parameter int               DATA_W    = 32,
    parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] stat_q
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic bit_q;
            // Next state: event forces 1, otherwise a written 1 inverts.
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= evt[i] | (bit_q ^ (wr & wdata[i]));
            end
            assign stat_q[i] = bit_q;
        end else begin : g_rsvd
            assign stat_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_enable_reg.sv
// Enable register: plain read/write storage for the implemented bits.
// Unimplemented bits read zero and ignore writes.
module irq_enable_reg #(
    parameter int               DATA_W    = 32,
    parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q
);
    logic [DATA_W-1:0] store_q;

    // Capture the masked write data on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  store_q <= '0;
        else if (wr) store_q <= wdata & IMPL_MASK;
    end

    assign en_q = store_q & IMPL_MASK;
endmodule

// File: rtl/irq_line_reduce.sv
// Interrupt line: registered OR of the set-and-enabled bits in one group.
// Assumes GROUP_MASK selects that group's bit range.
module irq_line_reduce #(
    parameter int               DATA_W     = 32,
    parameter logic [DATA_W-1:0] GROUP_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] stat,
    input  logic [DATA_W-1:0] en,
    output logic              irq
);
    // One flop after the AND-OR tree, so the line is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(stat & en & GROUP_MASK);
    end
endmodule

// File: rtl/net_irq_status_ctrl.sv
// Split interrupt status controller: sticky status, enable mask and two
// registered interrupt lines (receive and transmit groups).
// Assumes one register access per cycle with no wait states and
// combinational read data.
module net_irq_status_ctrl #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int RX_LO  = 16,
    parameter int RX_HI  = 25,
    parameter int TX_LO  = 0,
    parameter int TX_HI  = 6,
    parameter int TX_GAP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] evt_in,
    output logic              irq_rx,
    output logic              irq_tx
);
    import net_irq_pkg::*;

    localparam logic [DATA_W-1:0] RX_MASK   = DATA_W'(span_mask(RX_LO, RX_HI));
    localparam logic [DATA_W-1:0] TX_MASK   =
        DATA_W'(span_mask(TX_LO, TX_HI) & ~(64'd1 << TX_GAP));
    localparam logic [DATA_W-1:0] IMPL_MASK = RX_MASK | TX_MASK;

    reg_sel_e          sel;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] en_q;
    logic              wr_stat;
    logic              wr_en;

    irq_addr_decode #(
        .ADDR_W  (ADDR_W),
        .OFF_STAT(ADDR_W'(0)),
        .OFF_EN  (ADDR_W'(4))
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    assign wr_stat = bus_we && (sel == SEL_STAT);
    assign wr_en   = bus_we && (sel == SEL_EN);

    irq_status_bits #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_stat),
        .wdata (bus_wdata),
        .evt   (evt_in),
        .stat_q(stat_q)
    );

    irq_enable_reg #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (wr_en),
        .wdata(bus_wdata),
        .en_q (en_q)
    );

    irq_line_reduce #(.DATA_W(DATA_W), .GROUP_MASK(RX_MASK)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .stat (stat_q),
        .en   (en_q),
        .irq  (irq_rx)
    );

    irq_line_reduce #(.DATA_W(DATA_W), .GROUP_MASK(TX_MASK)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .stat (stat_q),
        .en   (en_q),
        .irq  (irq_tx)
    );

    // Read mux: the addressed register, or zero for an unmapped address.
    always_comb begin
        case (sel)
            SEL_STAT: bus_rdata = stat_q;
            SEL_EN:   bus_rdata = en_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/net_irq_status_ctrl_chk.sv
// Checker for net_irq_status_ctrl. It observes ports and the status and
// enable state over time. It is bound into every instance of the top.
module net_irq_status_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int RX_LO  = 16,
    parameter int RX_HI  = 25,
    parameter int TX_LO  = 0,
    parameter int TX_HI  = 6,
    parameter int TX_GAP = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] evt_in,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic [DATA_W-1:0] stat_q,
    input logic [DATA_W-1:0] en_q
);
    import net_irq_pkg::*;

    localparam logic [DATA_W-1:0] RXM  = DATA_W'(span_mask(RX_LO, RX_HI));
    localparam logic [DATA_W-1:0] TXM  =
        DATA_W'(span_mask(TX_LO, TX_HI) & ~(64'd1 << TX_GAP));
    localparam logic [DATA_W-1:0] IMPL = RXM | TXM;

    logic          st_wr;
    logic          en_wr;
    logic [DATA_W-1:0] ev_impl;
    assign st_wr   = bus_we && (bus_addr == ADDR_W'(0));
    assign en_wr   = bus_we && (bus_addr == ADDR_W'(4));
    assign ev_impl = evt_in & IMPL;

    p_rsvd_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL) == '0);

    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_impl != '0) |=> ((stat_q & $past(ev_impl)) == $past(ev_impl)));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_wr && ev_impl == '0) |=> $stable(stat_q));

    p_write_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && ev_impl == '0) |=> (stat_q == $past(stat_q ^ (bus_wdata & IMPL))));

    p_event_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && (ev_impl & bus_wdata) != '0)
        |=> ((stat_q & $past(ev_impl & bus_wdata)) == $past(ev_impl & bus_wdata)));

    p_rx_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_rx == $past(|(stat_q & en_q & RXM))));

    p_tx_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_tx == $past(|(stat_q & en_q & TXM))));

    p_enable_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q == $past(bus_wdata & IMPL)));

    p_enable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_q));
endmodule

bind net_irq_status_ctrl net_irq_status_ctrl_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RX_LO(RX_LO), .RX_HI(RX_HI),
    .TX_LO(TX_LO), .TX_HI(TX_HI), .TX_GAP(TX_GAP)
) u_chk (.*);

// File: tb/net_irq_status_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: directed checks with literal expectations, plus a behavioural
// model compared at every falling edge. Inputs change 2 ns after a rising edge.
module net_irq_status_ctrl_bench;
    localparam logic [31:0] RX_BITS = 32'h03FF_0000;
    localparam logic [31:0] TX_BITS = 32'h0000_005F;
    localparam logic [31:0] IMPL    = RX_BITS | TX_BITS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_in = '0;
    logic        irq_rx, irq_tx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    net_irq_status_ctrl u_net_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    // Behavioural reference model.
    logic [31:0] m_stat = '0, m_en = '0;
    logic        m_rx = 1'b0, m_tx = 1'b0;

    always @(posedge clk) begin
        logic [31:0] nxt;
        if (!rst_n) begin
            m_stat <= '0; m_en <= '0; m_rx <= 1'b0; m_tx <= 1'b0;
        end else begin
            nxt = m_stat;
            for (int b = 0; b < 32; b++) begin
                if (IMPL[b]) begin
                    if (evt_in[b])
                        nxt[b] = 1'b1;
                    else if (bus_we && bus_addr == 4'h0 && bus_wdata[b])
                        nxt[b] = !m_stat[b];
                end
            end
            m_stat <= nxt;
            if (bus_we && bus_addr == 4'h4) m_en <= bus_wdata & IMPL;
            m_rx <= (m_stat & m_en & RX_BITS) != 0;
            m_tx <= (m_stat & m_en & TX_BITS) != 0;
        end
    end

    function automatic logic [31:0] model_read();
        if (bus_addr == 4'h0) return m_stat;
        if (bus_addr == 4'h4) return m_en;
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R1..R10 all covered here).
    always @(negedge clk) begin
        if (!done && rst_n) begin
            check("R2/R3/R4/R5/R6/R9/R10 rdata", bus_rdata, model_read());
            check("R7 irq_rx", {31'b0, irq_rx}, {31'b0, m_rx});
            check("R8 irq_tx", {31'b0, irq_tx}, {31'b0, m_tx});
        end
    end

    // One bus cycle: drive after the rising edge, return at the falling edge.
    task automatic cyc(input logic [3:0] a, input logic we, input logic [31:0] wd,
                       input logic [31:0] ev);
        @(posedge clk);
        #2;
        bus_addr = a; bus_we = we; bus_wdata = wd; evt_in = ev;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state
        @(negedge clk);
        bus_addr = 4'h0; #1;
        check("R1 status reset", bus_rdata, 32'h0);
        bus_addr = 4'h4; #1;
        check("R1 enable reset", bus_rdata, 32'h0);
        check("R1 irq reset", {30'b0, irq_rx, irq_tx}, 32'h0);
        @(posedge clk); #2; rst_n = 1'b1;

        // R3: single-cycle pulses set sticky bits
        cyc(4'h0, 1'b0, 32'h0, 32'h0001_0008);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R3 pulse sets", bus_rdata, 32'h0001_0008);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R3 sticky", bus_rdata, 32'h0001_0008);
        check("R7 masked while disabled", {31'b0, irq_rx}, 32'h0);

        // R9: enable register write, masked readback
        cyc(4'h4, 1'b1, 32'hFFFF_FFFF, 32'h0);
        cyc(4'h4, 1'b0, 32'h0, 32'h0);
        check("R9 enable readback", bus_rdata, 32'h03FF_005F);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R7 rx asserted", {31'b0, irq_rx}, 32'h1);
        check("R8 tx asserted", {31'b0, irq_tx}, 32'h1);

        // R4: write 1 clears a set bit, groups independent
        cyc(4'h0, 1'b1, 32'h0000_0008, 32'h0);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R4 clear", bus_rdata, 32'h0001_0000);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R8 tx drops", {31'b0, irq_tx}, 32'h0);
        check("R7 rx unaffected", {31'b0, irq_rx}, 32'h1);

        // R4: write 0 has no effect
        cyc(4'h0, 1'b1, 32'h0, 32'h0);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R4 write zero", bus_rdata, 32'h0001_0000);

        // R5: diagnostic set of a clear bit
        cyc(4'h0, 1'b1, 32'h0000_0040, 32'h0);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R5 diag set", bus_rdata, 32'h0001_0040);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R8 tx from diag", {31'b0, irq_tx}, 32'h1);

        // R2: writes and events on unimplemented bits ignored
        cyc(4'h0, 1'b1, 32'hFC00_FFA0, 32'h0);
        cyc(4'h0, 1'b0, 32'h0, 32'hFC00_FFA0);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R2 reserved ignored", bus_rdata, 32'h0001_0040);

        // R6: event beats clearing write
        cyc(4'h0, 1'b1, 32'h0001_0000, 32'h0001_0000);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R6 event wins", bus_rdata, 32'h0001_0040);
        check("R7 rx held", {31'b0, irq_rx}, 32'h1);

        // R7: masking by enable
        cyc(4'h4, 1'b1, 32'h0000_0040, 32'h0);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R7 rx masked", {31'b0, irq_rx}, 32'h0);
        check("R8 tx enabled", {31'b0, irq_tx}, 32'h1);

        // R10: unmapped address
        cyc(4'h8, 1'b1, 32'hFFFF_FFFF, 32'h0);
        check("R10 unmapped reads zero", bus_rdata, 32'h0);
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        check("R10 status untouched", bus_rdata, 32'h0001_0040);
        cyc(4'h4, 1'b0, 32'h0, 32'h0);
        check("R10 enable untouched", bus_rdata, 32'h0000_0040);

        // Random traffic, compared against the model every cycle.
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] a;
            case ($urandom % 4)
                0, 1: a = 4'h0;
                2:    a = 4'h4;
                default: a = 4'h8;
            endcase
            cyc(a, 1'($urandom % 2), $urandom, $urandom & $urandom & $urandom);
        end
        cyc(4'h0, 1'b0, 32'h0, 32'h0);
        finish_run();
    end
endmodule